// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns bytes written on a simple data port into asynchronous serial frames. Each byte goes into a sixteen-entry queue. A shift engine takes bytes from the queue in the order they were written and sends each one as a frame: a start bit, eight data bits, an optional parity bit and one or two stop bits. A bus slave or a DMA channel can feed the data port; both use the same one-cycle write strobe.

Bit timing comes from an external oversampling strobe. Every serial bit lasts sixteen strobes. Software selects the bit order, parity, stop length and line polarity. The block reports a fixed four-bit state code, a ready flag and the queue occupancy. It raises a completion interrupt once the queue has drained and the engine is idle, which is how the end of a DMA-fed burst is detected. A master enable must be set before anything is accepted or sent.

Top module: `uart_tx_fifo`

## Requirements
- R1: The queue holds 16 bytes and `fifo_level` reports its occupancy from 0 to 16. A write while the queue is full is dropped: the level stays at 16 and the stored bytes are sent unchanged.
- R2: Each frame is a start bit (logic 0), 8 data bits, a parity bit when `cfg_parity_en` is 1, then one stop bit (logic 1), or two when `cfg_two_stop` is 1. Every bit lasts 16 pulses of `tick`.
- R3: With `cfg_msb_first` at 0 the data bits go out least significant first. With it at 1 they go out most significant first.
- R4: The parity bit is the XOR of the eight data bits when `cfg_parity_odd` is 0 (even parity). It is the inverse of that XOR when `cfg_parity_odd` is 1 (odd parity).
- R5: With `cfg_invert` at 0, `txd` carries the logic level and idles at 1. With `cfg_invert` at 1, `txd` is the inverse of the logic level and idles at 0.
- R6: `tx_state` reads 0 when idle, 1 during the start bit, 2 during data bits, 3 during the parity bit and 4 during stop bits. `tx_ready` is 1 exactly when `tx_state` is 0.
- R7: `irq_tx` is 1 exactly when `irq_en` and `cfg_enable` are both 1, `fifo_level` is 0 and `tx_state` is 0.
- R8: While `cfg_enable` is 0, writes are ignored. From the clock after `cfg_enable` goes low, the queue is empty and the engine is idle, even if it was mid-frame.
- R9: Bytes are sent in the order they were written, one complete frame per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oversampling strobe, one clock wide, 16 per bit |
| cfg_enable | input | 1 | Master enable |
| cfg_msb_first | input | 1 | 1 sends the most significant data bit first |
| cfg_invert | input | 1 | 1 makes the line active-low |
| cfg_parity_en | input | 1 | Adds a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity |
| cfg_two_stop | input | 1 | 1 sends two stop bits |
| irq_en | input | 1 | Enables the completion interrupt |
| wr_valid | input | 1 | Data port write strobe |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line |
| tx_ready | output | 1 | 1 when idle, 0 while sending |
| tx_state | output | 4 | Engine state code |
| fifo_level | output | 5 | Queue occupancy, 0 to 16 |
| irq_tx | output | 1 | Completion interrupt |

## Verification
The assertions assume that `tick` is never high on two clocks in a row and that the frame settings change only while the engine is idle. Settings are captured when a frame starts, so a change mid-frame would otherwise make the state checks depend on timing. The directed stimulus drives `tick` as a one-cycle pulse every fourth clock. It changes configuration only after waiting for `tx_ready`, except in the disable scenario, where dropping `cfg_enable` mid-frame is the behaviour under test.

// File: rtl/uart_tx_pkg.sv
// Package: shared types for the buffered serial transmitter.
// Assumes: the state codes are visible to software and must not change.
package uart_tx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_START  = 4'd1,
        ST_DATA   = 4'd2,
        ST_PARITY = 4'd3,
        ST_STOP   = 4'd4
    } tx_state_e;

endpackage

// File: rtl/uart_tx_queue.sv
// Module: circular byte queue with an occupancy count.
// Does: accepts a push when not full and a pop when not empty, in the same cycle if need be.
// Assumes: the caller checks nothing itself; a push while full and a pop while empty are ignored here.
module uart_tx_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (level == '0);
    assign full     = (level == LW'(DEPTH));
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    // Storage write: only an accepted push touches the array.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy update, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
// Module: frame serializer.
// Does: on a load request while idle, captures a byte and the frame settings, then walks
//       start, data, optional parity and stop bits, each lasting OSR ticks.
// Assumes: tick is a single-cycle strobe; the line output is the logic level (no polarity).
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    localparam int TW    = (OSR > 1) ? $clog2(OSR) : 1,
    localparam int BW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              msb_first,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    output tx_state_e         state,
    output logic              line
);

    logic [TW-1:0]     tick_cnt;
    logic [BW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] reversed;
    logic              par_bit;
    logic              par_en_q;
    logic              two_stop_q;
    logic              stop_idx;
    logic              bit_end;

    // Mirror the byte so the shift always leaves from bit 0.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            reversed[i] = load_data[DATA_W-1-i];
        end
    end

    assign bit_end = tick && (tick_cnt == TW'(OSR - 1));

    // Frame sequencer: loads a byte, counts ticks and advances through the bit slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tick_cnt   <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
            stop_idx   <= 1'b0;
        end else if (!enable) begin
            state    <= ST_IDLE;
            tick_cnt <= '0;
        end else if (state == ST_IDLE) begin
            if (load) begin
                shreg      <= msb_first ? reversed : load_data;
                par_bit    <= (^load_data) ^ parity_odd;
                par_en_q   <= parity_en;
                two_stop_q <= two_stop;
                tick_cnt   <= '0;
                bit_idx    <= '0;
                stop_idx   <= 1'b0;
                state      <= ST_START;
            end
        end else if (tick) begin
            tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            if (bit_end) begin
                unique case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == BW'(DATA_W - 1)) begin
                            state <= par_en_q ? ST_PARITY : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_PARITY: state <= ST_STOP;
                    ST_STOP: begin
                        if (two_stop_q && !stop_idx) stop_idx <= 1'b1;
                        else                         state    <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Logic level on the line for the current bit slot.
    always_comb begin
        unique case (state)
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_bit;
            default:   line = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_fifo.sv
// Module: buffered serial transmitter top.
// Does: queues written bytes, hands them to the serializer while it is idle,
//       applies line polarity and produces status and the completion interrupt.
// Assumes: frame settings change only while idle; tick comes from an external baud divider.
module uart_tx_fifo
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int OSR    = 16,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_enable,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    input  logic              irq_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic [3:0]        tx_state,
    output logic [LW-1:0]     fifo_level,
    output logic              irq_tx
);

    logic [DATA_W-1:0] q_data;
    logic              q_empty;
    logic              q_full;
    logic              take;
    logic              line;
    tx_state_e         state;

    assign take = cfg_enable && (state == ST_IDLE) && !q_empty;

    uart_tx_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!cfg_enable),
        .push      (wr_valid && cfg_enable),
        .push_data (wr_data),
        .pop       (take),
        .pop_data  (q_data),
        .level     (fifo_level),
        .empty     (q_empty),
        .full      (q_full)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .tick       (tick),
        .load       (take),
        .load_data  (q_data),
        .msb_first  (cfg_msb_first),
        .parity_en  (cfg_parity_en),
        .parity_odd (cfg_parity_odd),
        .two_stop   (cfg_two_stop),
        .state      (state),
        .line       (line)
    );

    // Status, polarity and interrupt outputs.
    always_comb begin
        txd      = line ^ cfg_invert;
        tx_state = state;
        tx_ready = (state == ST_IDLE);
        irq_tx   = irq_en && cfg_enable && q_empty && (state == ST_IDLE);
    end

endmodule

// File: rtl/uart_tx_fifo_chk.sv
// Module: property checker for the buffered serial transmitter, bound to the top.
// Assumes: observes top-level ports only; reset is synchronous active-low.
module uart_tx_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          cfg_invert,
    input logic          irq_en,
    input logic          wr_valid,
    input logic          txd,
    input logic          tx_ready,
    input logic [3:0]    tx_state,
    input logic [LW-1:0] fifo_level,
    input logic          irq_tx
);

    p_level_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && wr_valid && fifo_level == LW'(DEPTH) && tx_state != 4'd0)
        |=> (fifo_level == LW'(DEPTH)));

    p_start_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state == 4'd1) |-> (txd == cfg_invert));

    p_mark_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state == 4'd0 || tx_state == 4'd4) |-> (txd != cfg_invert));

    p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready == (tx_state == 4'd0));

    p_state_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_state <= 4'd4);

    p_irq_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (irq_en && cfg_enable && fifo_level == '0 && tx_state == 4'd0));

    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (fifo_level == '0 && tx_state == 4'd0));

endmodule

bind uart_tx_fifo uart_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_invert (cfg_invert),
    .irq_en     (irq_en),
    .wr_valid   (wr_valid),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .tx_state   (tx_state),
    .fifo_level (fifo_level),
    .irq_tx     (irq_tx)
);

// File: tb/uart_tx_fifo_tb.sv
module uart_tx_fifo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       irq_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       tx_ready;
    logic [3:0] tx_state;
    logic [4:0] fifo_level;
    logic       irq_tx;

    int n_checks = 0;
    int n_fails  = 0;
    logic [1:0] tick_div = 2'd0;

    uart_tx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_enable(cfg_enable),
        .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop), .irq_en(irq_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .txd(txd), .tx_ready(tx_ready), .tx_state(tx_state),
        .fifo_level(fifo_level), .irq_tx(irq_tx)
    );

    always #2 clk = ~clk;

    // One-cycle tick every fourth clock.
    always @(posedge clk) begin
        tick_div <= tick_div + 2'd1;
        tick     <= (tick_div == 2'd3);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!tick);
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!tx_ready);
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Receive one frame, sampling mid-bit, and compare with the expected content.
    task automatic rx_frame(input logic [7:0] exp, input string req);
        logic [7:0] got = 8'h00;
        logic       start_lvl = cfg_invert;
        do @(negedge clk); while (txd != start_lvl);
        wait_ticks(8);
        chk(txd == start_lvl && tx_state == 4'd1, "R2 start bit", {tx_state, txd}, {4'd1, start_lvl});
        for (int i = 0; i < 8; i++) begin
            wait_ticks(16);
            if (i == 0) chk(tx_state == 4'd2 && !tx_ready, "R6 data state", {tx_ready, tx_state}, 2);
            if (cfg_msb_first) got = {got[6:0], txd ^ cfg_invert};
            else               got = {txd ^ cfg_invert, got[7:1]};
        end
        chk(got == exp, req, got, exp);
        if (cfg_parity_en) begin
            wait_ticks(16);
            chk(tx_state == 4'd3 && (txd ^ cfg_invert) == ((^exp) ^ cfg_parity_odd),
                "R4 parity bit", {tx_state, txd ^ cfg_invert}, {4'd3, (^exp) ^ cfg_parity_odd});
        end
        wait_ticks(16);
        chk(tx_state == 4'd4 && (txd ^ cfg_invert) == 1'b1, "R2 stop bit", {tx_state, txd}, {4'd4, !cfg_invert});
        if (cfg_two_stop) begin
            wait_ticks(16);
            chk(tx_state == 4'd4 && (txd ^ cfg_invert) == 1'b1, "R2 second stop", {tx_state, txd}, {4'd4, !cfg_invert});
        end
    endtask

    task automatic t_reset();
        chk(txd == 1'b1, "R5 reset idle line", txd, 1);
        chk(tx_ready && tx_state == 4'd0, "R6 reset state", {tx_ready, tx_state}, {1'b1, 4'd0});
        chk(fifo_level == 5'd0 && !irq_tx, "R1 reset level", {fifo_level, irq_tx}, 0);
    endtask

    task automatic t_lsb_first();
        push_byte(8'hA5);
        rx_frame(8'hA5, "R3 lsb first");
        wait_idle();
    endtask

    task automatic t_msb_first();
        cfg_msb_first = 1'b1;
        push_byte(8'h1E);
        rx_frame(8'h1E, "R3 msb first");
        wait_idle();
        cfg_msb_first = 1'b0;
    endtask

    task automatic t_parity();
        cfg_parity_en = 1'b1;
        cfg_parity_odd = 1'b0;
        push_byte(8'hB7);
        rx_frame(8'hB7, "R4 even parity data");
        wait_idle();
        cfg_parity_odd = 1'b1;
        push_byte(8'hB6);
        rx_frame(8'hB6, "R4 odd parity data");
        wait_idle();
        cfg_parity_en = 1'b0;
        cfg_parity_odd = 1'b0;
    endtask

    task automatic t_two_stop();
        cfg_two_stop = 1'b1;
        push_byte(8'h81);
        rx_frame(8'h81, "R2 two stop data");
        wait_idle();
        cfg_two_stop = 1'b0;
    endtask

    task automatic t_invert();
        cfg_invert = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0, "R5 inverted idle", txd, 0);
        push_byte(8'h5A);
        rx_frame(8'h5A, "R5 inverted data");
        wait_idle();
        cfg_invert = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R5 normal idle", txd, 1);
    endtask

    // Fill past capacity while the first byte is in flight; the extra write must vanish.
    task automatic t_fill();
        fork
            begin
                for (int i = 0; i < 18; i++) begin
                    @(negedge clk);
                    wr_valid = 1'b1;
                    wr_data  = 8'h30 + 8'(i);
                end
                @(negedge clk);
                wr_valid = 1'b0;
                chk(fifo_level == 5'd16, "R1 full level", fifo_level, 16);
                chk(!irq_tx, "R7 no irq while full", irq_tx, 0);
            end
            begin
                for (int i = 0; i < 17; i++) begin
                    rx_frame(8'h30 + 8'(i), "R9 order");
                end
            end
        join
        wait_idle();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (!tx_ready) break;
        end
        chk(tx_ready && fifo_level == 5'd0, "R1 dropped write not sent", {tx_ready, fifo_level}, {1'b1, 5'd0});
    endtask

    task automatic t_irq();
        @(negedge clk);
        chk(!irq_tx, "R7 masked", irq_tx, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq_tx, "R7 drained and idle", irq_tx, 1);
        push_byte(8'h77);
        @(negedge clk);
        chk(!irq_tx, "R7 low while sending", irq_tx, 0);
        rx_frame(8'h77, "R7 frame");
        wait_idle();
        @(negedge clk);
        chk(irq_tx, "R7 high after drain", irq_tx, 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk(!irq_tx, "R7 disabled", irq_tx, 0);
    endtask

    task automatic t_disable();
        cfg_enable = 1'b0;
        push_byte(8'h99);
        chk(fifo_level == 5'd0 && tx_ready, "R8 write ignored", {tx_ready, fifo_level}, {1'b1, 5'd0});
        cfg_enable = 1'b1;
        push_byte(8'h12);
        push_byte(8'h34);
        wait_ticks(40);
        chk(tx_state == 4'd2 && fifo_level == 5'd1, "R8 mid frame", {tx_state, fifo_level}, {4'd2, 5'd1});
        cfg_enable = 1'b0;
        @(negedge clk);
        chk(tx_state == 4'd0 && fifo_level == 5'd0 && txd == 1'b1, "R8 abort",
            {tx_state, fifo_level, txd}, {4'd0, 5'd0, 1'b1});
        cfg_enable = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd != 1'b1) break;
        end
        chk(txd == 1'b1 && tx_ready, "R8 nothing left after flush", {tx_ready, txd}, 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_enable = 1'b1;
        t_lsb_first();
        t_msb_first();
        t_parity();
        t_two_stop();
        t_invert();
        t_fill();
        t_irq();
        t_disable();
        finish_run();
    end

endmodule